// File: doc/BRIEF.md
# Boot-block flash command interface

This block is the write and control front end of a small boot-block flash memory, written as a synthesizable behavioural model. The host drives an asynchronous-style bus with three active-low strobes: chip enable, output enable and write enable. The block samples these strobes in its own clock domain. A bus write completes when write enable goes high after a cycle in which chip enable and write enable were both low. At that moment the address and data inputs are taken.

Written bytes pass through a command decoder. The decoder supports a two-write program sequence, a two-write block erase sequence, selection of read-array or read-status mode, and clearing of the status error flags. The array is small and split into equal blocks. Programming can only clear bits. Erasing sets a whole block to 0xFF. A write-protect input guards the lowest blocks (two by default). An operation that write-protect refuses, or an erase with a bad confirm byte, is reported through sticky error bits in the status byte and does not change the array.

An active-low reset/power-down input turns the data outputs off and resets the control logic. When it rises, the block is in read-array mode. The array contents are not reset by it.

Top module: `bootflash_cmd`

## Requirements
- R1: A bus write is taken only at the first clock where `we_n` reads high after a clock in which both `ce_n` and `we_n` read low. The address and data are taken at that clock. A `we_n` pulse with `ce_n` held high has no effect.
- R2: `dout_en` is 1 exactly when `pwrdn_n` is 1 and `ce_n` and `oe_n` are both 0.
- R3: While `pwrdn_n` is 0, `dout_en` is 0 and all command state is cleared. This includes a half-entered sequence. After release, the mode is read-array and the status byte reads 0x80.
- R4: The byte 0x40 followed by a second write programs the word at the second write's address. The new value is the old value AND the written data.
- R5: The byte 0x20 followed by 0xD0 sets every word to 0xFF in the block selected by the upper `ADDR_W-BLK_W` bits of the confirm write's address.
- R6: If the second byte of an erase sequence is not 0xD0, status bits 5 and 4 are set and the array is unchanged.
- R7: Blocks with an index below `LOCK_N` are locked while `wp_n` is 0. A program to a locked block sets status bits 4 and 1. An erase of a locked block sets status bits 5 and 1. In both cases the array is unchanged. Unlocked blocks can always be changed.
- R8: Status bit 7 reads 0 for `BUSY_CYC` clocks after an accepted program or erase, then reads 1. Bus writes taken while it reads 0 are ignored.
- R9: Status bits 5, 4 and 1 stay set until the byte 0x50 is written. Writing 0x50 clears them and leaves the mode unchanged.
- R10: In read-status mode `dout` shows the status byte. Its layout is: bit 7 ready, bit 5 erase error, bit 4 program error, bit 1 lock error, and the remaining bits 0. The byte 0x70 selects read-status mode and 0xFF selects read-array mode. In read-array mode `dout` shows the word at `addr`.
- R11: After a program or erase sequence, accepted or refused, the mode remains read-status until 0xFF is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| pwrdn_n | input | 1 | Reset/power-down, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp_n | input | 1 | Write protect, active low, locks the lowest blocks |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Command or program data |
| dout | output | 8 | Read data: array word or status byte |
| dout_en | output | 1 | Output drive enable; low means high impedance |

## Verification
Two events can land on the same clock: the last clock of the busy countdown and a new bus write. The outcome depends on whether the write sees the ready flag as 0 or 1. To provoke this, the bench sends a read-array command at a sweep of gaps after a program. The write edge therefore falls a few clocks before, exactly at, and after the countdown reaches zero. Every clock, a behavioural reference model judges `dout_en` and `dout`. The model tracks mode, pending sequence, error flags, busy count and array contents.

// File: rtl/bf_pkg.sv
package bf_pkg;

    typedef enum logic [0:0] {
        RMODE_ARRAY  = 1'b0,
        RMODE_STATUS = 1'b1
    } rmode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PROG  = 2'd1,
        SEQ_ERASE = 2'd2
    } seq_e;

    typedef struct packed {
        logic erase_err;
        logic prog_err;
        logic lock_err;
    } err_t;

    localparam logic [7:0] OP_PROG_SETUP  = 8'h40;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_READ_STAT   = 8'h70;
    localparam logic [7:0] OP_CLEAR_STAT  = 8'h50;
    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;

endpackage

// File: rtl/bf_bus_edge.sv
module bf_bus_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic wr_stb
);

    typedef struct packed {
        logic ce_low;
        logic we_low;
    } seen_t;

    seen_t seen_d, seen_q;

    always_comb begin
        seen_d.ce_low = !ce_n;
        seen_d.we_low = !we_n;
        wr_stb        = seen_q.ce_low && seen_q.we_low && we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

    // R1: a strobe needs a prior cycle with both enables low
    p_strobe_needs_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!ce_n && !we_n));

endmodule

// File: rtl/bf_cmd_fsm.sv
module bf_cmd_fsm #(
    parameter int ADDR_W   = 6,
    parameter int BLK_W    = 4,
    parameter int LOCK_N   = 2,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic              wp_n,
    output logic              prog_en,
    output logic              erase_en,
    output logic              show_status,
    output logic [7:0]        status
);
    import bf_pkg::*;

    localparam int SEL_W = ADDR_W - BLK_W;
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        rmode_e           mode;
        seq_e             seq;
        err_t             err;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic locked;
    logic ready;

    always_comb begin
        ctl_d    = ctl_q;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        ready    = (ctl_q.cnt == '0);
        locked   = !wp_n && (waddr[ADDR_W-1:BLK_W] < SEL_W'(LOCK_N));

        if (!ready) ctl_d.cnt = ctl_q.cnt - CNT_W'(1);

        if (wr_stb && ready) begin
            unique case (ctl_q.seq)
                SEQ_PROG: begin
                    ctl_d.seq  = SEQ_IDLE;
                    ctl_d.mode = RMODE_STATUS;
                    if (locked) begin
                        ctl_d.err.lock_err = 1'b1;
                        ctl_d.err.prog_err = 1'b1;
                    end else begin
                        prog_en   = 1'b1;
                        ctl_d.cnt = CNT_W'(BUSY_CYC);
                    end
                end
                SEQ_ERASE: begin
                    ctl_d.seq  = SEQ_IDLE;
                    ctl_d.mode = RMODE_STATUS;
                    if (wdata != OP_ERASE_GO) begin
                        ctl_d.err.erase_err = 1'b1;
                        ctl_d.err.prog_err  = 1'b1;
                    end else if (locked) begin
                        ctl_d.err.lock_err  = 1'b1;
                        ctl_d.err.erase_err = 1'b1;
                    end else begin
                        erase_en  = 1'b1;
                        ctl_d.cnt = CNT_W'(BUSY_CYC);
                    end
                end
                default: begin
                    unique case (wdata)
                        OP_PROG_SETUP: begin
                            ctl_d.seq  = SEQ_PROG;
                            ctl_d.mode = RMODE_STATUS;
                        end
                        OP_ERASE_SETUP: begin
                            ctl_d.seq  = SEQ_ERASE;
                            ctl_d.mode = RMODE_STATUS;
                        end
                        OP_READ_STAT:  ctl_d.mode = RMODE_STATUS;
                        OP_CLEAR_STAT: ctl_d.err  = '0;
                        OP_READ_ARRAY: ctl_d.mode = RMODE_ARRAY;
                        default: ;
                    endcase
                end
            endcase
        end

        show_status = (ctl_q.mode == RMODE_STATUS);
        status = {ready, 1'b0, ctl_q.err.erase_err, ctl_q.err.prog_err,
                  2'b00, ctl_q.err.lock_err, 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mode <= RMODE_ARRAY;
            ctl_q.seq  <= SEQ_IDLE;
            ctl_q.err  <= '0;
            ctl_q.cnt  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R5: program and erase never fire together
    p_single_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en && erase_en));

    // R7: an array change never targets a locked block
    p_lock_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |-> (wp_n || waddr[ADDR_W-1:BLK_W] >= SEL_W'(LOCK_N)));

    // R8: an accepted operation reloads the busy count
    p_busy_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |=> (ctl_q.cnt == CNT_W'(BUSY_CYC)));

    // R8: writes taken while busy leave the sequence state alone
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ctl_q.cnt != '0) |=> (ctl_q.seq == $past(ctl_q.seq)));

    // R9: program error stays until a clear command
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.err.prog_err && !(wr_stb && ctl_q.cnt == '0 && ctl_q.seq == SEQ_IDLE
                                 && wdata == OP_CLEAR_STAT))
        |=> ctl_q.err.prog_err);

    // R11: status mode follows any started operation
    p_status_after_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en) |=> (ctl_q.mode == RMODE_STATUS));

    // R3: release from power-down lands in read-array mode
    p_wake_array_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctl_q.mode == RMODE_ARRAY));

endmodule

// File: rtl/bf_array.sv
module bf_array #(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              prog_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [ADDR_W-1:0] WA = ADDR_W'(g);
        logic [7:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (erase_en && waddr[ADDR_W-1:BLK_W] == WA[ADDR_W-1:BLK_W])
                word_d = 8'hFF;
            else if (prog_en && waddr == WA)
                word_d = word_q & wdata;
        end

        always_ff @(posedge clk) begin
            word_q <= word_d;
        end

        assign words[g] = word_q;
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/bootflash_cmd.sv
module bootflash_cmd #(
    parameter int ADDR_W   = 6,
    parameter int BLK_W    = 4,
    parameter int LOCK_N   = 2,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              pwrdn_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);

    logic       wr_stb;
    logic       prog_en;
    logic       erase_en;
    logic       show_status;
    logic [7:0] status;
    logic [7:0] arr_data;

    bf_bus_edge i_edge (
        .clk    (clk),
        .rst_n  (pwrdn_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .wr_stb (wr_stb)
    );

    bf_cmd_fsm #(
        .ADDR_W   (ADDR_W),
        .BLK_W    (BLK_W),
        .LOCK_N   (LOCK_N),
        .BUSY_CYC (BUSY_CYC)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (pwrdn_n),
        .wr_stb      (wr_stb),
        .waddr       (addr),
        .wdata       (din),
        .wp_n        (wp_n),
        .prog_en     (prog_en),
        .erase_en    (erase_en),
        .show_status (show_status),
        .status      (status)
    );

    bf_array #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W)
    ) i_array (
        .clk      (clk),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .waddr    (addr),
        .wdata    (din),
        .raddr    (addr),
        .rdata    (arr_data)
    );

    always_comb begin
        dout_en = pwrdn_n && !ce_n && !oe_n;
        dout    = show_status ? status : arr_data;
    end

endmodule

// File: tb/test_bootflash_cmd.sv
module test_bootflash_cmd;

    localparam int AW   = 6;
    localparam int BUSY = 4;
    localparam int NW   = 1 << AW;

    logic          clk = 1'b0;
    logic          pwrdn_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wp_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    bootflash_cmd #(.ADDR_W(AW), .BLK_W(4), .LOCK_N(2), .BUSY_CYC(BUSY)) i_bootflash_cmd (
        .clk(clk), .pwrdn_n(pwrdn_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wp_n(wp_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #5 clk = ~clk;

    // reference model state
    int  m_mem [NW];
    bit  m_known [NW];
    bit  m_stat, m_elock, m_eprog, m_eerase;
    int  m_seq, m_cnt;
    bit  m_ce_low, m_we_low, m_ev;

    function automatic logic [7:0] m_status();
        return {m_cnt == 0, 1'b0, m_eerase, m_eprog, 2'b00, m_elock, 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic m_apply(input int a, input int d);
        bit lk = !wp_n && (a / 16 < 2);
        if (m_seq == 1) begin
            m_seq = 0; m_stat = 1;
            if (lk) begin m_elock = 1; m_eprog = 1; end
            else begin m_mem[a] = m_mem[a] & d; m_cnt = BUSY; end
        end else if (m_seq == 2) begin
            m_seq = 0; m_stat = 1;
            if (d != 8'hD0) begin m_eerase = 1; m_eprog = 1; end
            else if (lk) begin m_elock = 1; m_eerase = 1; end
            else begin
                for (int i = 0; i < NW; i++)
                    if (i / 16 == a / 16) begin m_mem[i] = 8'hFF; m_known[i] = 1; end
                m_cnt = BUSY;
            end
        end else begin
            case (d)
                8'h40: begin m_seq = 1; m_stat = 1; end
                8'h20: begin m_seq = 2; m_stat = 1; end
                8'h70: m_stat = 1;
                8'h50: begin m_elock = 0; m_eprog = 0; m_eerase = 0; end
                8'hFF: m_stat = 0;
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (!pwrdn_n) begin
            m_stat = 0; m_elock = 0; m_eprog = 0; m_eerase = 0;
            m_seq = 0; m_cnt = 0; m_ce_low = 0; m_we_low = 0;
        end else begin
            m_ev = m_ce_low && m_we_low && we_n;
            if (m_ev && m_cnt == 0) m_apply(int'(addr), int'(din));
            else if (m_cnt > 0) m_cnt--;
            m_ce_low = !ce_n;
            m_we_low = !we_n;
        end
    end

    // per-clock comparison against the model
    always @(posedge clk) begin
        bit exp_en;
        #3;
        exp_en = pwrdn_n && !ce_n && !oe_n;
        check(dout_en == exp_en, "R2", dout_en, exp_en);
        if (exp_en && dout_en) begin
            if (m_stat) check(dout == m_status(), "R10", dout, m_status());
            else if (m_known[addr]) check(dout == m_mem[addr][7:0], "R4", dout, m_mem[addr]);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); addr = AW'(a); din = 8'(d); ce_n = 0; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk); addr = AW'(a); ce_n = 0; oe_n = 0;
        @(posedge clk); #3;
        check(dout_en && dout == 8'(exp), req, dout, exp);
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic settle();
        repeat (BUSY + 2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R3: outputs off during power-down even with both enables low
        repeat (2) @(negedge clk);
        ce_n = 0; oe_n = 0;
        @(posedge clk); #3;
        check(dout_en == 1'b0, "R3", dout_en, 0);
        @(negedge clk); ce_n = 1; oe_n = 1; pwrdn_n = 1;

        wr(0, 8'h70);
        rd(0, 8'h80, "R3");

        for (int b = 0; b < 4; b++) begin
            wr(b * 16, 8'h20); wr(b * 16, 8'hD0); settle();
        end
        wr(0, 8'hFF);
        rd(5, 8'hFF, "R5");
        rd(40, 8'hFF, "R5");

        // R4 / R8: program, busy then ready
        wr(33, 8'h40); wr(33, 8'h5A);
        rd(0, 8'h00, "R8");
        settle();
        rd(0, 8'h80, "R8");
        wr(0, 8'hFF);
        rd(33, 8'h5A, "R4");
        wr(33, 8'h40); wr(33, 8'h0F); settle();
        // R11: clear status leaves mode in status
        wr(0, 8'h50);
        rd(33, 8'h80, "R11");
        wr(0, 8'hFF);
        rd(33, 8'h0A, "R4");

        // R1: we pulse without chip enable is ignored
        @(negedge clk); addr = 33; din = 8'h70; we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk);
        rd(33, 8'h0A, "R1");

        // R7: lockable blocks under write protect
        wr(20, 8'h40); wr(20, 8'h33); settle();
        wr(50, 8'h40); wr(50, 8'h77); settle();
        wp_n = 0;
        wr(3, 8'h40); wr(3, 8'h00);
        rd(3, 8'h92, "R7");
        wr(0, 8'h50);
        wr(20, 8'h20); wr(20, 8'hD0);
        rd(20, 8'hA2, "R7");
        wr(0, 8'h50);
        wr(34, 8'h40); wr(34, 8'hF0); settle();
        wr(0, 8'hFF);
        rd(3, 8'hFF, "R7");
        rd(20, 8'h33, "R7");
        rd(34, 8'hF0, "R7");
        wp_n = 1;
        wr(3, 8'h40); wr(3, 8'h11); settle();
        wr(0, 8'hFF);
        rd(3, 8'h11, "R7");

        // R6 / R9: bad confirm, sticky errors
        wr(48, 8'h20); wr(48, 8'h55);
        rd(48, 8'hB0, "R6");
        wr(0, 8'hFF);
        rd(50, 8'h77, "R6");
        wr(0, 8'h70);
        rd(0, 8'hB0, "R9");
        wr(0, 8'h50);
        rd(0, 8'h80, "R9");
        wr(0, 8'hFF);

        // R8: write during busy ignored
        wr(35, 8'h40); wr(35, 8'h3C); wr(0, 8'hFF);
        settle();
        rd(35, 8'h80, "R8");
        wr(0, 8'hFF);
        rd(35, 8'h3C, "R4");

        // R3: power-down drops a half-entered program
        wr(36, 8'h40);
        @(negedge clk); pwrdn_n = 0;
        repeat (2) @(negedge clk); pwrdn_n = 1;
        wr(36, 8'h00);
        rd(36, 8'hFF, "R3");

        // R8: sweep a command across the end of the busy window
        for (int gap = 0; gap < 7; gap++) begin
            wr(37, 8'h40); wr(37, 8'hFF ^ (1 << gap));
            repeat (gap) @(negedge clk);
            wr(0, 8'hFF);
            settle();
            rd(37, m_stat ? int'(m_status()) : m_mem[37], "R8");
            wr(0, 8'hFF);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule